// File: doc/BRIEF.md
# Supply and Overvoltage Protection Supervisor

This block is the digital supervisor of a boundary-mode power-factor controller. It receives comparator flags that are already synchronised to its clock. From them it decides whether the power switch may run, whether the controller goes into its low-power disabled state, and whether the "output ready" signal to downstream converters is released. Every threshold with hysteresis arrives as two flags: one for crossing the upper level and one for crossing the lower level. The supervisor keeps the state between those two crossings.

Switching is allowed only when none of these conditions is active:

- supply lockout;
- feedback overvoltage;
- auxiliary-pin overvoltage latch;
- feedback-low disable.

The two overvoltage paths recover in different ways:

- **Feedback overvoltage** recovers by itself once feedback falls below its lower level.
- **Auxiliary-pin overvoltage** stays latched. It clears only after the supply has passed down through the stop level, back up through the start level, and the auxiliary pin is below its release level at that point.

The ready output models an open-drain pin, with 1 meaning released (pulled high, ready active). It follows feedback with its own hysteresis and does not depend on switching. A supply below the floor level forces it low.

Top module: `sup_ovp_supervisor`

## Requirements
- R1: After synchronous reset, sw_en = 0 (lockout), low_pwr = 0, rdy_hiz = 1, and the auxiliary overvoltage latch is clear.
- R2: While no other condition is active, sup_start_ok = 1 with sup_stop_low = 0 sampled at a clock edge ends lockout, so sw_en = 1 after that edge.
- R3: With both supply flags at 0, the lockout state holds. sup_stop_low = 1 at an edge enters lockout, so sw_en = 0 after that edge, and sup_stop_low takes priority over sup_start_ok.
- R4: fb_ov_hi = 1 at an edge gives sw_en = 0 after that edge. fb_ov_lo = 1 (with fb_ov_hi = 0) at an edge ends this condition.
- R5: With fb_ov_hi = 0 and fb_ov_lo = 0, the feedback overvoltage condition keeps its state.
- R6: aux_ov_hi = 1 at an edge latches the auxiliary overvoltage, so sw_en = 0 after that edge. aux_ov_lo alone, without a supply cycle, does not clear the latch.
- R7: The latch clears at the first edge after a sup_stop_low = 1 edge at which sup_start_ok = 1, sup_stop_low = 0, aux_ov_lo = 1 and aux_ov_hi = 0.
- R8: If the supply comes back above start while aux_ov_lo = 0, the latch stays set, and a later aux_ov_lo without another supply cycle leaves it set.
- R9: fb_dis_lo = 1 at an edge gives low_pwr = 1 and sw_en = 0 after that edge. fb_dis_rel = 1 (with fb_dis_lo = 0) ends the disabled state.
- R10: With sup_floor_low = 0, fb_rdy_hi = 1 sets rdy_hiz = 1 and fb_rdy_lo = 1 (with fb_rdy_hi = 0) sets rdy_hiz = 0. With neither flag set, rdy_hiz holds.
- R11: sup_floor_low = 1 at an edge gives rdy_hiz = 0 after that edge, even when fb_rdy_hi = 1.
- R12: rdy_hiz is independent of sw_en. It stays 1 while switching is stopped by lockout or a fault.
- R13: For the feedback overvoltage, disable and ready hysteresis conditions, the upper-crossing flag wins when both flags of a pair are 1 at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sup_start_ok | input | 1 | Supply above start level |
| sup_stop_low | input | 1 | Supply below stop level |
| sup_floor_low | input | 1 | Supply below the ready floor level |
| fb_ov_hi | input | 1 | Feedback above overvoltage trip level |
| fb_ov_lo | input | 1 | Feedback below overvoltage release level |
| aux_ov_hi | input | 1 | Auxiliary pin above its trip level |
| aux_ov_lo | input | 1 | Auxiliary pin below its release level |
| fb_dis_lo | input | 1 | Feedback below disable level |
| fb_dis_rel | input | 1 | Feedback above disable release level |
| fb_rdy_hi | input | 1 | Feedback above ready set level |
| fb_rdy_lo | input | 1 | Feedback below ready clear level |
| sw_en | output | 1 | Switching allowed |
| low_pwr | output | 1 | Low-power disable mode |
| rdy_hiz | output | 1 | Ready pin released (1) or pulled low (0) |

## Verification
The bench focuses on the auxiliary latch's recovery order:

- A design that clears the latch on the release flag alone restarts switching without a supply cycle.
- A design that clears it merely on re-crossing the start level restarts while the pin is still high.

It checks that sup_stop_low wins over sup_start_ok. It also checks the supply floor overriding a simultaneous ready set; a design that got this priority wrong would release the ready pin on a collapsing supply. Finally, it holds each hysteresis pair between its two crossings and checks that the state does not drift, and it confirms that ready stays released while switching is blocked.

// File: rtl/sup_ovp_pkg.sv
package sup_ovp_pkg;

    // hysteresis channels handled by the generic cell
    localparam int NUM_HYST = 3;
    localparam int HY_FBOV  = 0;
    localparam int HY_DIS   = 1;
    localparam int HY_RDY   = 2;

    // reset value per channel: only the ready pin starts released
    localparam logic [NUM_HYST-1:0] HY_RST = 3'b100;

    typedef struct packed {
        logic set;
        logic clr;
    } hyst_req_t;

    typedef enum logic [1:0] {
        OV2_CLEAR   = 2'd0,
        OV2_TRIPPED = 2'd1,
        OV2_ARMED   = 2'd2
    } ov2_state_e;

    typedef struct packed {
        logic lockout;
        logic fb_ov;
        logic aux_ov;
        logic disabled;
    } fault_t;

    function automatic logic fault_any(input fault_t f);
        return f.lockout | f.fb_ov | f.aux_ov | f.disabled;
    endfunction

endpackage

// File: rtl/sup_uvlo.sv
module sup_uvlo (
    input  logic clk,
    input  logic rst,
    input  logic sup_start_ok,
    input  logic sup_stop_low,
    output logic lockout
);
    logic lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b1;
        end else if (sup_stop_low) begin
            lock_q <= 1'b1;
        end else if (sup_start_ok) begin
            lock_q <= 1'b0;
        end
    end

    assign lockout = lock_q;

    AST_LOCK_EXIT: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_q) |-> $past(sup_start_ok) && !$past(sup_stop_low)); // R2

    AST_LOCK_ENTER: assert property (@(posedge clk) disable iff (rst)
        sup_stop_low |=> lock_q); // R3

endmodule

// File: rtl/sup_hyst_cell.sv
module sup_hyst_cell
    import sup_ovp_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic      clk,
    input  logic      rst,
    input  hyst_req_t req,
    input  logic      force_off,
    output logic      q
);
    logic st_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= RST_VAL;
        end else if (force_off) begin
            st_q <= 1'b0;
        end else if (req.set) begin
            st_q <= 1'b1;
        end else if (req.clr) begin
            st_q <= 1'b0;
        end
    end

    assign q = st_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (req.set && !force_off) |=> st_q); // R13

    AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (rst)
        (!req.set && !req.clr && !force_off) |=> $stable(st_q)); // R5

endmodule

// File: rtl/sup_ov2_latch.sv
module sup_ov2_latch
    import sup_ovp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic aux_ov_hi,
    input  logic aux_ov_lo,
    input  logic sup_start_ok,
    input  logic sup_stop_low,
    output logic active
);
    ov2_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        case (st_q)
            OV2_CLEAR:   if (aux_ov_hi) st_d = OV2_TRIPPED;
            OV2_TRIPPED: if (sup_stop_low) st_d = OV2_ARMED;
            OV2_ARMED:   if (sup_start_ok && !sup_stop_low && aux_ov_lo && !aux_ov_hi)
                             st_d = OV2_CLEAR;
            default:     st_d = OV2_TRIPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= OV2_CLEAR;
        else     st_q <= st_d;
    end

    assign active = (st_q != OV2_CLEAR);

    AST_OV2_HOLD: assert property (@(posedge clk) disable iff (rst)
        (st_q == OV2_TRIPPED) |=> (st_q != OV2_CLEAR)); // R6

    AST_OV2_SET: assert property (@(posedge clk) disable iff (rst)
        aux_ov_hi |=> active); // R6

endmodule

// File: rtl/sup_ovp_supervisor.sv
module sup_ovp_supervisor
    import sup_ovp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sup_start_ok,
    input  logic sup_stop_low,
    input  logic sup_floor_low,
    input  logic fb_ov_hi,
    input  logic fb_ov_lo,
    input  logic aux_ov_hi,
    input  logic aux_ov_lo,
    input  logic fb_dis_lo,
    input  logic fb_dis_rel,
    input  logic fb_rdy_hi,
    input  logic fb_rdy_lo,
    output logic sw_en,
    output logic low_pwr,
    output logic rdy_hiz
);
    hyst_req_t             req [NUM_HYST];
    logic [NUM_HYST-1:0]   frc;
    logic [NUM_HYST-1:0]   hq;
    logic                  lockout;
    logic                  aux_active;
    fault_t                flt;

    assign req[HY_FBOV] = '{set: fb_ov_hi,  clr: fb_ov_lo};
    assign req[HY_DIS]  = '{set: fb_dis_lo, clr: fb_dis_rel};
    assign req[HY_RDY]  = '{set: fb_rdy_hi, clr: fb_rdy_lo};

    assign frc[HY_FBOV] = 1'b0;
    assign frc[HY_DIS]  = 1'b0;
    assign frc[HY_RDY]  = sup_floor_low;

    for (genvar g = 0; g < NUM_HYST; g++) begin : g_hyst
        sup_hyst_cell #(.RST_VAL(HY_RST[g])) u_cell (
            .clk       (clk),
            .rst       (rst),
            .req       (req[g]),
            .force_off (frc[g]),
            .q         (hq[g])
        );
    end

    sup_uvlo u_uvlo (
        .clk          (clk),
        .rst          (rst),
        .sup_start_ok (sup_start_ok),
        .sup_stop_low (sup_stop_low),
        .lockout      (lockout)
    );

    sup_ov2_latch u_ov2 (
        .clk          (clk),
        .rst          (rst),
        .aux_ov_hi    (aux_ov_hi),
        .aux_ov_lo    (aux_ov_lo),
        .sup_start_ok (sup_start_ok),
        .sup_stop_low (sup_stop_low),
        .active       (aux_active)
    );

    assign flt = '{lockout:  lockout,
                   fb_ov:    hq[HY_FBOV],
                   aux_ov:   aux_active,
                   disabled: hq[HY_DIS]};

    assign sw_en   = ~fault_any(flt);
    assign low_pwr = hq[HY_DIS];
    assign rdy_hiz = hq[HY_RDY];

    AST_FBOV_STOP: assert property (@(posedge clk) disable iff (rst)
        fb_ov_hi |=> !sw_en); // R4

    AST_UVLO_STOP: assert property (@(posedge clk) disable iff (rst)
        sup_stop_low |=> !sw_en); // R3

    AST_DIS_LPWR: assert property (@(posedge clk) disable iff (rst)
        fb_dis_lo |=> (low_pwr && !sw_en)); // R9

    AST_RDY_FLOOR: assert property (@(posedge clk) disable iff (rst)
        sup_floor_low |=> !rdy_hiz); // R11

endmodule

// File: tb/tb_sup_ovp_supervisor.sv
`timescale 1ns/1ps
module tb_sup_ovp_supervisor;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sup_start_ok = 0, sup_stop_low = 0, sup_floor_low = 0;
    logic fb_ov_hi = 0, fb_ov_lo = 0, aux_ov_hi = 0, aux_ov_lo = 0;
    logic fb_dis_lo = 0, fb_dis_rel = 0, fb_rdy_hi = 0, fb_rdy_lo = 0;
    logic sw_en, low_pwr, rdy_hiz;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 0;

    // behavioural reference state
    int m_lock = 1, m_fbov = 0, m_aux = 0, m_dis = 0, m_rdy = 1;
    bit m_seen_low = 0;

    always #2 clk = ~clk;

    sup_ovp_supervisor dut (
        .clk(clk), .rst(rst),
        .sup_start_ok(sup_start_ok), .sup_stop_low(sup_stop_low),
        .sup_floor_low(sup_floor_low),
        .fb_ov_hi(fb_ov_hi), .fb_ov_lo(fb_ov_lo),
        .aux_ov_hi(aux_ov_hi), .aux_ov_lo(aux_ov_lo),
        .fb_dis_lo(fb_dis_lo), .fb_dis_rel(fb_dis_rel),
        .fb_rdy_hi(fb_rdy_hi), .fb_rdy_lo(fb_rdy_lo),
        .sw_en(sw_en), .low_pwr(low_pwr), .rdy_hiz(rdy_hiz)
    );

    // reference model: evaluated from the requirements at each edge
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (rst) begin
            m_lock <= 1; m_fbov <= 0; m_aux <= 0; m_dis <= 0; m_rdy <= 1;
            m_seen_low <= 0;
        end else begin
            if (sup_stop_low) m_lock <= 1;
            else if (sup_start_ok) m_lock <= 0;
            if (fb_ov_hi) m_fbov <= 1; else if (fb_ov_lo) m_fbov <= 0;
            if (fb_dis_lo) m_dis <= 1; else if (fb_dis_rel) m_dis <= 0;
            if (sup_floor_low) m_rdy <= 0;
            else if (fb_rdy_hi) m_rdy <= 1;
            else if (fb_rdy_lo) m_rdy <= 0;
            if (m_aux == 0) begin
                if (aux_ov_hi) begin m_aux <= 1; m_seen_low <= 0; end
            end else if (!m_seen_low) begin
                if (sup_stop_low) m_seen_low <= 1;
            end else if (sup_start_ok && !sup_stop_low && aux_ov_lo && !aux_ov_hi) begin
                m_aux <= 0; m_seen_low <= 0;
            end
        end
    end

    task automatic check(input logic act, input logic exp, input string req, input string what);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // continuous comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            check(sw_en, (m_lock == 0 && m_fbov == 0 && m_aux == 0 && m_dis == 0), "R2", "model sw_en");
            check(low_pwr, (m_dis != 0), "R9", "model low_pwr");
            check(rdy_hiz, (m_rdy != 0), "R10", "model rdy_hiz");
        end
    end

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic idle();
        sup_start_ok = 0; sup_stop_low = 0; sup_floor_low = 0;
        fb_ov_hi = 0; fb_ov_lo = 0; aux_ov_hi = 0; aux_ov_lo = 0;
        fb_dis_lo = 0; fb_dis_rel = 0; fb_rdy_hi = 0; fb_rdy_lo = 0;
    endtask

    initial begin
        #100000;
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        rst = 1;
        tick(3);
        rst = 0;
        tick(1);
        check(sw_en, 1'b0, "R1", "reset sw_en");
        check(low_pwr, 1'b0, "R1", "reset low_pwr");
        check(rdy_hiz, 1'b1, "R1", "reset rdy_hiz");

        // start-up
        sup_start_ok = 1; tick(1); sup_start_ok = 0;
        check(sw_en, 1'b1, "R2", "start crossing");
        tick(4);
        check(sw_en, 1'b1, "R3", "hold between levels");
        sup_stop_low = 1; sup_start_ok = 1; tick(1); sup_stop_low = 0; sup_start_ok = 0;
        check(sw_en, 1'b0, "R3", "stop wins over start");
        sup_start_ok = 1; tick(1); sup_start_ok = 0;
        check(sw_en, 1'b1, "R2", "restart");

        // feedback overvoltage
        fb_ov_hi = 1; tick(1); fb_ov_hi = 0;
        check(sw_en, 1'b0, "R4", "fb ov trip");
        tick(3);
        check(sw_en, 1'b0, "R5", "fb ov hold");
        fb_ov_lo = 1; tick(1); fb_ov_lo = 0;
        check(sw_en, 1'b1, "R4", "fb ov recover");
        fb_ov_hi = 1; fb_ov_lo = 1; tick(1); fb_ov_hi = 0; fb_ov_lo = 0;
        check(sw_en, 1'b0, "R13", "set wins");
        fb_ov_lo = 1; tick(1); fb_ov_lo = 0;

        // auxiliary overvoltage latch
        aux_ov_hi = 1; tick(1); aux_ov_hi = 0;
        check(sw_en, 1'b0, "R6", "aux trip");
        aux_ov_lo = 1; tick(3); aux_ov_lo = 0;
        check(sw_en, 1'b0, "R6", "aux release alone");
        sup_stop_low = 1; tick(1); sup_stop_low = 0;
        sup_start_ok = 1; tick(1); sup_start_ok = 0;
        check(sw_en, 1'b0, "R8", "supply back, pin high");
        aux_ov_lo = 1; tick(2); aux_ov_lo = 0;
        check(sw_en, 1'b0, "R8", "late release");
        sup_stop_low = 1; tick(1); sup_stop_low = 0;
        sup_start_ok = 1; aux_ov_lo = 1; tick(1); sup_start_ok = 0; aux_ov_lo = 0;
        check(sw_en, 1'b1, "R7", "aux cleared after cycle");

        // disable
        fb_dis_lo = 1; tick(1); fb_dis_lo = 0;
        check(low_pwr, 1'b1, "R9", "disable low_pwr");
        check(sw_en, 1'b0, "R9", "disable sw_en");
        fb_dis_rel = 1; tick(1); fb_dis_rel = 0;
        check(low_pwr, 1'b0, "R9", "disable release");
        check(sw_en, 1'b1, "R9", "disable release sw");

        // ready pin
        fb_rdy_lo = 1; tick(1); fb_rdy_lo = 0;
        check(rdy_hiz, 1'b0, "R10", "ready clear");
        tick(2);
        check(rdy_hiz, 1'b0, "R10", "ready hold low");
        fb_rdy_hi = 1; tick(1); fb_rdy_hi = 0;
        check(rdy_hiz, 1'b1, "R10", "ready set");
        sup_stop_low = 1; tick(1); sup_stop_low = 0;
        check(sw_en, 1'b0, "R12", "switching stopped");
        check(rdy_hiz, 1'b1, "R12", "ready kept while stopped");
        sup_floor_low = 1; fb_rdy_hi = 1; tick(1); sup_floor_low = 0; fb_rdy_hi = 0;
        check(rdy_hiz, 1'b0, "R11", "floor forces low");

        // random traffic compared against the model each cycle
        for (int i = 0; i < 4000; i++) begin
            sup_start_ok  = ($urandom_range(0, 9) == 0);
            sup_stop_low  = ($urandom_range(0, 19) == 0);
            sup_floor_low = ($urandom_range(0, 29) == 0);
            fb_ov_hi      = ($urandom_range(0, 19) == 0);
            fb_ov_lo      = ($urandom_range(0, 7) == 0);
            aux_ov_hi     = ($urandom_range(0, 49) == 0);
            aux_ov_lo     = ($urandom_range(0, 2) == 0);
            fb_dis_lo     = ($urandom_range(0, 29) == 0);
            fb_dis_rel    = ($urandom_range(0, 5) == 0);
            fb_rdy_hi     = ($urandom_range(0, 7) == 0);
            fb_rdy_lo     = ($urandom_range(0, 7) == 0);
            tick(1);
        end
        idle();
        tick(1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule